// File: doc/BRIEF.md
# Write-Through Data Cache Controller with Per-Access Uncached Bypass

This block sits between a processor load/store port and a word-wide main-memory port. It holds a small direct-mapped cache of multi-word lines. Every request carries an attribute bit that selects one of two treatments. A cacheable request uses write-through behaviour: a load looks in the cache first and fills the whole line from memory on a miss. A store always goes to memory and also updates the cached copy when it hits. A store miss never allocates a line. A request marked uncached goes straight to memory and never reads or changes the cache.

A separate lock command marks individual lines as locked or unlocked. A locked line that holds valid data is never evicted: a cacheable load that misses on it is served by one word read from memory, and the line keeps its contents. A store hit may still change a locked line. Each line keeps one valid bit per word. A line counts as empty only when all of its valid bits are clear, and a fill sets all of them.

The request side is valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold the request steady. `req_ready` drops for the whole memory phase of any request that touches memory, and comes back in the cycle after the last memory acknowledge. The load response is a one-cycle `rsp_valid` pulse with no back-pressure, because the requester has only one load outstanding. The memory side is a plain request/acknowledge pair: `mem_req` and its address, write enable and data stay fixed until a one-cycle `mem_ack`. Each acknowledge completes exactly one word.

Top module: `wt_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. Every line is empty and unlocked, so the first cacheable load to any line misses.
- R2: A cacheable load that misses on an empty or unlocked line reads the 4 words of its line from memory with offsets 0,1,2,3 in ascending order. It then returns the requested word with `rsp_valid` after the last acknowledge, and the line hits afterwards. The word address is {tag, index[2:0], offset[1:0]}, with the offset in bits 1:0 and the line index in bits 4:2.
- R3: A cacheable load that hits raises `rsp_valid` with the cached word in the cycle after acceptance. It makes no memory access and keeps `req_ready` high.
- R4: An uncached load performs exactly one memory read of its own address and returns that memory word, even when the line is resident with different (stale) data. It leaves the cache unchanged.
- R5: An uncached store performs exactly one memory write of its address and data. It leaves the cache unchanged even when the address is resident, so a later cacheable load still returns the old cached word.
- R6: A cacheable store that hits writes its data to memory and to the cached word.
- R7: A cacheable store that misses writes memory only and allocates nothing, so a later cacheable load of that address still misses.
- R8: A lock command (`lock_valid` high for one cycle) sets the line's lock bit when `lock_set` is 1 and clears it when `lock_set` is 0. A cacheable load miss on a locked line that holds valid data makes one memory read of the requested word, returns it, and does not replace the line. A locked empty line is still filled.
- R9: A store hit on a locked line updates both memory and the cached word.
- R10: While `mem_req` is high, `req_ready` is low. `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ack`.
- R11: Each `mem_ack` completes exactly one word: stores make one write beat, uncached loads and locked-line misses make one read beat, and fills make four read beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request (low = busy) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_uncached | input | 1 | 1 = uncached bypass, 0 = write-through cacheable |
| req_addr | input | ADDR_W (10) | Word address |
| req_wdata | input | DATA_W (32) | Store data |
| rsp_valid | output | 1 | One-cycle pulse: load data valid |
| rsp_rdata | output | DATA_W (32) | Load data |
| lock_valid | input | 1 | Apply a lock command this cycle |
| lock_set | input | 1 | 1 = lock line, 0 = unlock line |
| lock_idx | input | IDX_W (3) | Line index for the lock command |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W (10) | Memory word address |
| mem_wdata | output | DATA_W (32) | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current word |
| mem_rdata | input | DATA_W (32) | Read data, valid with `mem_ack` |

## Verification
The assertions assume that `mem_ack` only ever arrives while `mem_req` is high and lasts one cycle per word. They also assume that a request is held unchanged until it is accepted, and that lock commands arrive only while the block is idle. The bench's memory responder acknowledges only a request it has seen, with a rotating delay of zero to two cycles, and drops the acknowledge after one cycle. The request driver waits for `req_ready` before presenting anything and issues lock commands between requests. The bench then sweeps every line through every attribute, direction, hit/miss and lock combination. A long pseudo-random stream over three tags follows, and every result is compared against a reference model of the cache and of memory.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_FILL = 2'd1,
    S_RD1  = 2'd2,
    S_WR   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [OFF_W-1:0] rd_off,
  output logic             hit,
  output logic             line_valid,
  output logic             line_locked,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             lock_we,
  input  logic [IDX_W-1:0] lock_idx,
  input  logic             lock_val
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [WORDS-1:0] vld_q [LINES];
  logic [LINES-1:0] lck_q;
  logic [LINES-1:0] line_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        vld_q[i] <= '0;
      end
      lck_q <= '0;
    end else begin
      if (fill_we) begin
        tag_q[fill_idx] <= fill_tag;
        vld_q[fill_idx] <= '1;
      end
      if (lock_we) lck_q[lock_idx] <= lock_val;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign line_match[g] = vld_q[g][rd_off] && (tag_q[g] == rd_tag);
  end

  assign hit         = line_match[rd_idx];
  assign line_valid  = |vld_q[rd_idx];
  assign line_locked = lck_q[rd_idx];
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int AW     = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/wtc_seq.sv
module wtc_seq
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_uncached,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   hit,
  input  logic                   line_valid,
  input  logic                   line_locked,
  input  logic [DATA_W-1:0]      cache_rdata,
  output logic                   dw_we,
  output logic [IDX_W+OFF_W-1:0] dw_addr,
  output logic [DATA_W-1:0]      dw_data,
  output logic                   fill_we,
  output logic [IDX_W-1:0]       fill_idx,
  output logic [ADDR_W-IDX_W-OFF_W-1:0] fill_tag,
  output logic                   op_unc,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic                   mem_ack,
  input  logic [DATA_W-1:0]      mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  seq_state_t        st_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  beat_q;
  logic              unc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_idx;
  logic [OFF_W-1:0]  r_off;
  logic              accept;

  assign r_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign r_idx  = req_addr[OFF_W +: IDX_W];
  assign r_off  = req_addr[OFF_W-1:0];
  assign accept = req_valid && (st_q == S_IDLE);

  // Single write port into the data array: store hit at acceptance or fill beat.
  always_comb begin
    dw_we   = 1'b0;
    dw_addr = {r_idx, r_off};
    dw_data = req_wdata;
    if (st_q == S_FILL) begin
      dw_we   = mem_ack;
      dw_addr = {idx_q, beat_q};
      dw_data = mem_rdata;
    end else if (accept && req_write && !req_uncached && hit) begin
      dw_we = 1'b1;
    end
  end

  assign fill_we  = (st_q == S_FILL) && mem_ack && (beat_q == LAST_BEAT);
  assign fill_idx = idx_q;
  assign fill_tag = tag_q;
  assign op_unc   = unc_q;

  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;
  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = (st_q == S_FILL) ? {tag_q, idx_q, beat_q} : addr_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
      off_q   <= '0;
      beat_q  <= '0;
      unc_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (req_valid) begin
            tag_q   <= r_tag;
            idx_q   <= r_idx;
            off_q   <= r_off;
            unc_q   <= req_uncached;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            beat_q  <= '0;
            if (req_write) begin
              st_q <= S_WR;
            end else if (!req_uncached && hit) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= cache_rdata;
            end else if (!req_uncached && !(line_valid && line_locked)) begin
              st_q <= S_FILL;
            end else begin
              st_q <= S_RD1;
            end
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            if (beat_q == off_q) rsp_d_q <= mem_rdata;
            if (beat_q == LAST_BEAT) begin
              rsp_v_q <= 1'b1;
              st_q    <= S_IDLE;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        S_RD1: begin
          if (mem_ack) begin
            rsp_d_q <= mem_rdata;
            rsp_v_q <= 1'b1;
            st_q    <= S_IDLE;
          end
        end
        S_WR: begin
          if (mem_ack) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_uncached,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              lock_valid,
  input  logic              lock_set,
  input  logic [IDX_W-1:0]  lock_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int DA_W  = IDX_W + OFF_W;

  logic              lk_hit;
  logic              lk_line_valid;
  logic              lk_line_locked;
  logic [DATA_W-1:0] cache_rdata;
  logic              dat_we;
  logic [DA_W-1:0]   dat_waddr;
  logic [DATA_W-1:0] dat_wdata;
  logic              tag_fill_we;
  logic [IDX_W-1:0]  tag_fill_idx;
  logic [TAG_W-1:0]  tag_fill_tag;
  logic              op_unc;

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_tags (
    .clk         (clk),
    .rst         (rst),
    .rd_idx      (req_addr[OFF_W +: IDX_W]),
    .rd_tag      (req_addr[ADDR_W-1 -: TAG_W]),
    .rd_off      (req_addr[OFF_W-1:0]),
    .hit         (lk_hit),
    .line_valid  (lk_line_valid),
    .line_locked (lk_line_locked),
    .fill_we     (tag_fill_we),
    .fill_idx    (tag_fill_idx),
    .fill_tag    (tag_fill_tag),
    .lock_we     (lock_valid),
    .lock_idx    (lock_idx),
    .lock_val    (lock_set)
  );

  wtc_data_store #(.AW(DA_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .we    (dat_we),
    .waddr (dat_waddr),
    .wdata (dat_wdata),
    .raddr (req_addr[DA_W-1:0]),
    .rdata (cache_rdata)
  );

  wtc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_uncached (req_uncached),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .hit          (lk_hit),
    .line_valid   (lk_line_valid),
    .line_locked  (lk_line_locked),
    .cache_rdata  (cache_rdata),
    .dw_we        (dat_we),
    .dw_addr      (dat_waddr),
    .dw_data      (dat_wdata),
    .fill_we      (tag_fill_we),
    .fill_idx     (tag_fill_idx),
    .fill_tag     (tag_fill_tag),
    .op_unc       (op_unc),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_uncached,
  input logic              hit,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              dwe,
  input logic              fill_we,
  input logic              op_unc
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !mem_req && !rsp_valid));

  assert_hit_fast_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write && !req_uncached && hit)
      |=> (rsp_valid && req_ready && !mem_req));

  assert_unc_accept_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_uncached) |-> !dwe);

  assert_unc_busy_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && op_unc) |-> (!dwe && !fill_we));

  assert_store_to_mem_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=> (mem_req && mem_we));

  assert_store_miss_nocache_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write && !hit) |-> !dwe);

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_ack_in_req_R11: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> mem_req);
endmodule

bind wt_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_uncached (req_uncached),
  .hit          (lk_hit),
  .rsp_valid    (rsp_valid),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .dwe          (dat_we),
  .fill_we      (tag_fill_we),
  .op_unc       (op_unc)
);

// File: tb/wt_cache_tb.sv
module wt_cache_tb;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int IW    = 3;
  localparam int OW    = 2;
  localparam int TW    = AW - IW - OW;
  localparam int LINES = 1 << IW;
  localparam int WORDS = 1 << OW;
  localparam int MEMSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_uncached = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          lock_valid = 1'b0;
  logic          lock_set = 1'b0;
  logic [IW-1:0] lock_idx = '0;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .OFF_W(OW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_uncached(req_uncached), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lock_valid(lock_valid), .lock_set(lock_set), .lock_idx(lock_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  // memory responder and its bookkeeping
  logic [DW-1:0] tb_mem [MEMSZ];
  int            rd_cnt = 0;
  int            wr_cnt = 0;
  logic [AW-1:0] rd_log [4];
  logic [AW-1:0] last_wa = '0;
  logic [DW-1:0] last_wd = '0;
  int            lat_sel = 0;

  // reference model
  logic [DW-1:0] exp_mem [MEMSZ];
  logic [TW-1:0] m_tag [LINES];
  logic          m_val [LINES];
  logic          m_lck [LINES];
  logic [DW-1:0] m_dat [LINES*WORDS];

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) begin
      tb_mem[i]  = 32'hA500_0000 ^ (i * 32'h0001_0203);
      exp_mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
    end
    for (int i = 0; i < LINES; i++) begin
      m_val[i] = 1'b0;
      m_lck[i] = 1'b0;
      m_tag[i] = '0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat (lat_sel) @(negedge clk);
        lat_sel = (lat_sel + 1) % 3;
        if (mem_we) begin
          tb_mem[mem_addr] = mem_wdata;
          last_wa = mem_addr;
          last_wd = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = tb_mem[mem_addr];
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic do_lock(input logic [IW-1:0] idx, input logic setv);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lock_valid = 1'b1;
    lock_set   = setv;
    lock_idx   = idx;
    @(negedge clk);
    lock_valid = 1'b0;
    m_lck[idx] = setv;
  endtask

  task automatic do_op(input logic wr, input logic unc, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
    logic [IW-1:0] idx;
    logic [TW-1:0] tg;
    logic [OW-1:0] off;
    logic          mhit;
    logic          fill;
    int            exp_rd;
    logic [DW-1:0] exp_d;
    string         rq;
    int            cyc;
    idx  = a[OW +: IW];
    tg   = a[AW-1 -: TW];
    off  = a[OW-1:0];
    mhit = !unc && m_val[idx] && (m_tag[idx] == tg);
    fill = 1'b0;
    exp_rd = 0;
    exp_d  = '0;
    if (!wr) begin
      if (unc) begin rq = "R4"; exp_rd = 1; exp_d = exp_mem[a]; end
      else if (mhit) begin rq = "R3"; exp_d = m_dat[{idx, off}]; end
      else if (m_val[idx] && m_lck[idx]) begin rq = "R8"; exp_rd = 1; exp_d = exp_mem[a]; end
      else begin rq = "R2"; exp_rd = 4; fill = 1'b1; exp_d = exp_mem[a]; end
    end else begin
      if (unc) rq = "R5";
      else if (mhit) rq = m_lck[idx] ? "R9" : "R6";
      else rq = "R7";
    end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    req_valid    = 1'b1;
    req_write    = wr;
    req_uncached = unc;
    req_addr     = a;
    req_wdata    = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (!wr) begin
      while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
      chk({rq, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({rq, " load data"}, rsp_rdata, exp_d);
      if (mhit) chk("R3 hit latency", 32'(cyc), 32'd1);
      chk({rq, " R11 read beats"}, 32'(rd_cnt), 32'(exp_rd));
      chk({rq, " R11 write beats"}, 32'(wr_cnt), 32'd0);
      if (fill && rd_cnt == 4)
        for (int k = 0; k < 4; k++)
          chk("R2 fill order", 32'(rd_log[k]), 32'({tg, idx, OW'(k)}));
      if (fill) begin
        m_val[idx] = 1'b1;
        m_tag[idx] = tg;
        for (int k = 0; k < WORDS; k++)
          m_dat[{idx, OW'(k)}] = exp_mem[{tg, idx, OW'(k)}];
      end
    end else begin
      while (!req_ready && cyc < 100) begin @(negedge clk); cyc++; end
      chk({rq, " R10 ready back"}, 32'(req_ready), 32'd1);
      chk({rq, " R11 write beats"}, 32'(wr_cnt), 32'd1);
      chk({rq, " read beats"}, 32'(rd_cnt), 32'd0);
      chk({rq, " write addr"}, 32'(last_wa), 32'(a));
      chk({rq, " write data"}, last_wd, wd);
      exp_mem[a] = wd;
      if (mhit) m_dat[{idx, off}] = wd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);

    // directed sweep: every line, unlocked and locked
    for (int lk = 0; lk < 2; lk++) begin
      for (int li = 0; li < LINES; li++) begin
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        a = {TW'(lk * 7 + 1), IW'(li), OW'(li)};
        b = {TW'(lk * 7 + 3), IW'(li), OW'(li + 1)};
        do_lock(IW'(li), 1'b0);
        do_op(1'b0, 1'b0, a, '0);                     // R2 or R3
        if (lk == 1) do_lock(IW'(li), 1'b1);          // R8
        do_op(1'b0, 1'b0, a, '0);                     // R3 hit
        do_op(1'b0, 1'b1, a, '0);                     // R4
        do_op(1'b1, 1'b1, a, 32'hC0DE_0000 + li);     // R5 uncached store to resident
        do_op(1'b0, 1'b0, a, '0);                     // R5 stale word still hits
        do_op(1'b0, 1'b1, a, '0);                     // R4 sees memory not cache
        do_op(1'b1, 1'b0, a, 32'hBEEF_0000 + li);     // R6 / R9
        do_op(1'b0, 1'b0, a, '0);
        do_op(1'b1, 1'b0, b, 32'hF00D_0000 + li);     // R7 miss store
        do_op(1'b0, 1'b0, b, '0);                     // R7 still misses; R8 if locked
        do_op(1'b0, 1'b0, a, '0);                     // R8 locked line kept
        do_lock(IW'(li), 1'b0);
      end
    end

    // pseudo-random stream over three tags
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      if (lfsr[31:29] == 3'd0) begin
        do_lock(lfsr[IW+7:8], lfsr[20]);
      end else begin
        logic [AW-1:0] ra;
        ra = {TW'(lfsr[13:12] % 3), lfsr[IW+OW+3:4]};
        do_op(lfsr[24], lfsr[26] & lfsr[27], ra, lfsr ^ 32'h5A5A_0000);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule